// File: doc/BRIEF.md
# Four-Plane Graphics Memory Datapath

This block sits between a CPU byte bus and four 8-bit planar memories. It is the combine path of a planar graphics controller. A read strobe loads one byte from each plane at the given offset into four latches, one per plane. The byte returned to the CPU depends on the read mode: either one plane's byte, picked by a 2-bit map select, or a fixed zero.

A write strobe builds a new byte for each plane from the CPU byte, the latches and the set/reset bits. The write mode decides how. A logic function is applied to an operand and the latch, and a bit mask limits which bit positions change. A plane is written only when its map-mask bit is set.

The register values come in as plain inputs, sampled on the strobe cycle: read mode, write mode, function register, set/reset, set/reset enable, bit mask, map select and map mask. The plane memories are small internal arrays.

Top module: `vga_plane_datapath`

## Requirements
- R1: After rst_ni is released, every plane byte, every latch and rdata_o are 0x00.
- R2: A cycle with rd_en_i high loads the latch of every plane with that plane's byte at addr_i, as stored before any write in the same cycle.
- R3: With read_mode_i = 0, a read returns the byte of plane map_sel_i (0 to 3) at addr_i. rdata_o updates on the clock edge at which rd_en_i is high, and then holds until the next read.
- R4: With read_mode_i = 1, a read returns 0x00 and still loads all four latches.
- R5: fn_reg_i[4:3] selects the function of operand and latch: 00 operand, 01 AND, 10 OR, 11 XOR. The other bits of fn_reg_i, including the rotate count in bits 2:0, have no effect.
- R6: In write mode 0 (write_mode_i = 00), plane p takes as its operand set_reset_i[p] repeated 8 times when sr_enable_i[p] = 1. When sr_enable_i[p] = 0 its operand is wdata_i.
- R7: In write modes 0 and 2, a bit whose bit_mask_i bit is 0 takes the latch bit. A bit whose mask bit is 1 takes the function result.
- R8: In write mode 1 (write_mode_i = 01), plane p receives its latch unchanged.
- R9: In write mode 2 (write_mode_i = 10), plane p takes as its operand wdata_i[p] repeated 8 times.
- R10: Plane p is written only when map_mask_i[p] = 1. Every other plane keeps its byte.
- R11: In write mode 3 (write_mode_i = 11), no plane changes.
- R12: A write is committed on the clock edge at which wr_en_i is high, so a read in the next cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | CPU read strobe |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | ADDR_W | Byte offset within each plane |
| wdata_i | input | DATA_W | CPU write byte |
| read_mode_i | input | 1 | 0 = plane select, 1 = returns zero |
| write_mode_i | input | 2 | Write mode 0 to 3 |
| fn_reg_i | input | 8 | Function register; bits 4:3 pick the function |
| set_reset_i | input | NUM_PLANES | Set/reset value per plane |
| sr_enable_i | input | NUM_PLANES | Set/reset enable per plane |
| bit_mask_i | input | DATA_W | Bits that may change |
| map_sel_i | input | SEL_W | Plane returned in read mode 0 |
| map_mask_i | input | NUM_PLANES | Per-plane write enable |
| rdata_o | output | DATA_W | Registered read data |

## Verification
The bench targets the combinations where per-plane paths diverge. One case mixes set/reset-enabled and disabled planes in one write. If the enable is swapped or ignored, planes get the CPU byte where they should get the set/reset value. A partial bit mask with XOR and OR would expose a design that writes the function result into masked bits, or that clears them instead of keeping the latch. Other cases cover latch copies after a zero-returning read, a nonzero rotate field and write mode 3. If a design skips the latch load in read mode 1, gates planes with the wrong map-mask bit, or writes in mode 3, the readback of all four planes against a behavioural model shows a wrong byte.

// File: rtl/vga_dp_pkg.sv
package vga_dp_pkg;
  typedef enum logic [1:0] {FN_MOVE = 2'd0, FN_AND = 2'd1, FN_OR = 2'd2, FN_XOR = 2'd3} alu_fn_e;
  typedef enum logic [1:0] {WM_SETRST = 2'd0, WM_LATCH = 2'd1, WM_SPREAD = 2'd2, WM_HOLD = 2'd3} wr_mode_e;
endpackage

// File: rtl/plane_alu.sv
module plane_alu
  import vga_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  wr_mode_e          wmode_i,
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] cpu_byte_i,
  input  logic              cpu_bit_i,
  input  logic              sr_bit_i,
  input  logic              sr_en_i,
  input  logic [DATA_W-1:0] bit_mask_i,
  input  logic [DATA_W-1:0] latch_i,
  output logic [DATA_W-1:0] wr_byte_o
);
  logic [DATA_W-1:0] operand, fn_res, masked;

  always_comb begin
    if (wmode_i == WM_SPREAD)   operand = {DATA_W{cpu_bit_i}};
    else if (sr_en_i)           operand = {DATA_W{sr_bit_i}};
    else                        operand = cpu_byte_i;
  end

  always_comb begin
    unique case (fn_i)
      FN_AND:  fn_res = operand & latch_i;
      FN_OR:   fn_res = operand | latch_i;
      FN_XOR:  fn_res = operand ^ latch_i;
      default: fn_res = operand;
    endcase
  end

  assign masked    = (fn_res & bit_mask_i) | (latch_i & ~bit_mask_i);
  assign wr_byte_o = (wmode_i == WM_LATCH) ? latch_i : masked;

  // R7: masked-off bits always carry the latch
  always_comb begin
    if (wmode_i == WM_SETRST || wmode_i == WM_SPREAD)
      a_r7_mask_keeps_latch: assert (((wr_byte_o ^ latch_i) & ~bit_mask_i) == '0);
  end
endmodule

// File: rtl/plane_store.sv
module plane_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic [DATA_W-1:0] latch_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_byte_o = mem[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_o <= '0;
    else if (rd_en_i) latch_o <= rd_byte_o;
  end

  a_r2_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> latch_o == $past(rd_byte_o));

  a_r12_write_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/vga_plane_datapath.sv
module vga_plane_datapath
  import vga_dp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int NUM_PLANES = 4,
  localparam int SEL_W     = $clog2(NUM_PLANES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_en_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  read_mode_i,
  input  logic [1:0]            write_mode_i,
  input  logic [7:0]            fn_reg_i,
  input  logic [NUM_PLANES-1:0] set_reset_i,
  input  logic [NUM_PLANES-1:0] sr_enable_i,
  input  logic [DATA_W-1:0]     bit_mask_i,
  input  logic [SEL_W-1:0]      map_sel_i,
  input  logic [NUM_PLANES-1:0] map_mask_i,
  output logic [DATA_W-1:0]     rdata_o
);
  wr_mode_e          wmode;
  alu_fn_e           fn;
  logic [DATA_W-1:0] rd_byte [NUM_PLANES];
  logic [DATA_W-1:0] latch   [NUM_PLANES];
  logic [DATA_W-1:0] wr_byte [NUM_PLANES];
  logic [NUM_PLANES-1:0] plane_we;
  logic              unused_fn_bits;

  assign wmode          = wr_mode_e'(write_mode_i);
  assign fn             = alu_fn_e'(fn_reg_i[4:3]);
  assign unused_fn_bits = ^{fn_reg_i[7:5], fn_reg_i[2:0]};

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    plane_alu #(.DATA_W(DATA_W)) u_alu (
      .wmode_i    (wmode),
      .fn_i       (fn),
      .cpu_byte_i (wdata_i),
      .cpu_bit_i  (wdata_i[p]),
      .sr_bit_i   (set_reset_i[p]),
      .sr_en_i    (sr_enable_i[p]),
      .bit_mask_i (bit_mask_i),
      .latch_i    (latch[p]),
      .wr_byte_o  (wr_byte[p])
    );

    assign plane_we[p] = wr_en_i && map_mask_i[p] && (wmode != WM_HOLD);

    plane_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (rd_en_i),
      .we_i      (plane_we[p]),
      .addr_i    (addr_i),
      .wdata_i   (wr_byte[p]),
      .rd_byte_o (rd_byte[p]),
      .latch_o   (latch[p])
    );

    // R8: latch copy mode forwards the latch verbatim
    always_comb begin
      if (wmode == WM_LATCH)
        a_r8_latch_copy: assert (wr_byte[p] == latch[p]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= read_mode_i ? '0 : rd_byte[map_sel_i];
  end

  a_r3_read_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !read_mode_i |=> rdata_o == $past(rd_byte[map_sel_i]));

  a_r4_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && read_mode_i |=> rdata_o == '0);

  a_r3_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  a_r11_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_mode_i == 2'd3 |-> plane_we == '0);

  a_r10_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plane_we & ~map_mask_i) == '0);
endmodule

// File: tb/tb_vga_plane_datapath.sv
module tb_vga_plane_datapath;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_en_i = 0, wr_en_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       read_mode_i = 0;
  logic [1:0] write_mode_i = '0;
  logic [7:0] fn_reg_i = '0;
  logic [3:0] set_reset_i = '0, sr_enable_i = '0, map_mask_i = '0;
  logic [7:0] bit_mask_i = 8'hFF;
  logic [1:0] map_sel_i = '0;
  logic [7:0] rdata_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2 clk_i = ~clk_i;

  vga_plane_datapath dut (
    .clk_i, .rst_ni, .rd_en_i, .wr_en_i, .addr_i, .wdata_i, .read_mode_i,
    .write_mode_i, .fn_reg_i, .set_reset_i, .sr_enable_i, .bit_mask_i,
    .map_sel_i, .map_mask_i, .rdata_o
  );

  // behavioural reference model
  byte unsigned m_mem [4][DEPTH];
  byte unsigned m_lat [4];
  byte unsigned m_rd;

  function automatic byte unsigned m_fn(int f, byte unsigned a, byte unsigned b);
    case (f)
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      default: return a;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_mem[p, a]) m_mem[p][a] = 0;
      foreach (m_lat[p]) m_lat[p] = 0;
      m_rd = 0;
    end else begin
      byte unsigned nb [4];
      for (int p = 0; p < 4; p++) begin
        byte unsigned op, r;
        if (write_mode_i == 2) op = wdata_i[p] ? 8'hFF : 8'h00;
        else if (sr_enable_i[p]) op = set_reset_i[p] ? 8'hFF : 8'h00;
        else op = wdata_i;
        r = m_fn(int'(fn_reg_i[4:3]), op, m_lat[p]);
        nb[p] = 0;
        for (int b = 0; b < 8; b++) nb[p][b] = bit_mask_i[b] ? r[b] : m_lat[p][b];
        if (write_mode_i == 1) nb[p] = m_lat[p];
      end
      if (rd_en_i) begin
        for (int p = 0; p < 4; p++) m_lat[p] = m_mem[p][addr_i];
        m_rd = read_mode_i ? 8'h00 : m_mem[map_sel_i][addr_i];
      end
      if (wr_en_i && write_mode_i != 3)
        for (int p = 0; p < 4; p++) if (map_mask_i[p]) m_mem[p][addr_i] = nb[p];
    end
  end

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk_i) if (rst_ni) check({cur_req, " model"}, rdata_o, m_rd);

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sel, input logic mode,
                    output logic [7:0] got);
    @(negedge clk_i);
    rd_en_i = 1; addr_i = a; map_sel_i = sel; read_mode_i = mode;
    @(negedge clk_i);
    rd_en_i = 0;
    got = rdata_o;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [1:0] wm,
                    input logic [7:0] fr, input logic [3:0] sr, input logic [3:0] sre,
                    input logic [7:0] bm, input logic [3:0] mm);
    @(negedge clk_i);
    wr_en_i = 1; addr_i = a; wdata_i = d; write_mode_i = wm; fn_reg_i = fr;
    set_reset_i = sr; sr_enable_i = sre; bit_mask_i = bm; map_mask_i = mm;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic expect_planes(string req, logic [AW-1:0] a, logic [7:0] e0, logic [7:0] e1,
                               logic [7:0] e2, logic [7:0] e3);
    logic [7:0] g;
    logic [7:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    for (int p = 0; p < 4; p++) begin
      rd(a, 2'(p), 1'b0, g);
      check(req, g, e[p]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] g;
    repeat (3) @(negedge clk_i);
    check("R1 rdata reset", rdata_o, 8'h00);
    rst_ni = 1;
    cur_req = "R1";
    expect_planes("R1 planes reset", 6'd5, 8'h00, 8'h00, 8'h00, 8'h00);

    cur_req = "R6";
    wr(6'd3, 8'hA5, 2'd0, 8'h00, 4'h0, 4'h0, 8'hFF, 4'hF);
    expect_planes("R6/R12 cpu byte", 6'd3, 8'hA5, 8'hA5, 8'hA5, 8'hA5);

    // set/reset mix, XOR, partial mask, rotate field nonzero, plane 3 masked off
    cur_req = "R5";
    rd(6'd3, 2'd0, 1'b0, g);
    wr(6'd3, 8'h3C, 2'd0, 8'h1D, 4'b0001, 4'b0101, 8'h0F, 4'b0111);
    expect_planes("R5/R6/R7/R10 xor sr mix", 6'd3, 8'hAA, 8'hA9, 8'hA5, 8'hA5);

    cur_req = "R8";
    rd(6'd3, 2'd0, 1'b0, g);
    wr(6'd10, 8'h00, 2'd1, 8'h18, 4'hF, 4'hF, 8'h00, 4'hF);
    expect_planes("R2/R8 latch copy", 6'd10, 8'hAA, 8'hA9, 8'hA5, 8'hA5);

    cur_req = "R4";
    rd(6'd10, 2'd1, 1'b1, g);
    check("R4 read mode 1 zero", g, 8'h00);
    wr(6'd11, 8'h55, 2'd1, 8'h00, 4'h0, 4'h0, 8'hFF, 4'hF);
    expect_planes("R4 latches still loaded", 6'd11, 8'hAA, 8'hA9, 8'hA5, 8'hA5);

    cur_req = "R9";
    rd(6'd3, 2'd0, 1'b0, g);
    wr(6'd3, 8'h06, 2'd2, 8'h10, 4'h0, 4'hF, 8'hC3, 4'hF);
    expect_planes("R9/R7 spread OR", 6'd3, 8'hAA, 8'hEB, 8'hE7, 8'hA5);

    cur_req = "R11";
    rd(6'd3, 2'd0, 1'b0, g);
    wr(6'd3, 8'hFF, 2'd3, 8'h00, 4'hF, 4'hF, 8'hFF, 4'hF);
    expect_planes("R11 mode 3 no write", 6'd3, 8'hAA, 8'hEB, 8'hE7, 8'hA5);

    cur_req = "R3";
    rd(6'd3, 2'd1, 1'b0, g);
    repeat (3) @(negedge clk_i);
    check("R3 rdata held", rdata_o, 8'hEB);

    // random traffic against the model
    cur_req = "R5 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_i);
      rd_en_i = $urandom_range(0, 1); wr_en_i = $urandom_range(0, 1);
      addr_i = 6'($urandom_range(0, 7)); wdata_i = 8'($urandom);
      read_mode_i = ($urandom_range(0, 3) == 0); write_mode_i = 2'($urandom);
      fn_reg_i = 8'($urandom); set_reset_i = 4'($urandom); sr_enable_i = 4'($urandom);
      bit_mask_i = 8'($urandom); map_sel_i = 2'($urandom); map_mask_i = 4'($urandom);
    end
    @(negedge clk_i);
    rd_en_i = 0; wr_en_i = 0;
    cur_req = "R10 readback";
    for (int a = 0; a < 8; a++)
      for (int p = 0; p < 4; p++) rd(6'(a), 2'(p), 1'b0, g);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule